// File: doc/BRIEF.md
# Unavailable State Alarm Monitor

This block watches a line one second at a time and decides whether the line is in the unavailable state. Once per second an upstream qualifier raises `sec_tick` for one clock and, in the same cycle, marks that second with `sec_err` (errored) and `sec_sev` (severely errored). The monitor keeps a run-length counter. While the line is available, the counter measures a run of severely errored seconds. While it is unavailable, the counter measures a run of seconds that are errored but not severely errored. When a run reaches `RUN_LEN` (ten by default), the state flips and a one-cycle change pulse is sent out for use as an interrupt.

Two saturating performance counters follow the line quality: one for errored seconds and one for severely errored seconds. Both are frozen while the line is unavailable, and both can be cleared synchronously through `clr_cnt`. The seconds that made up an entry run stay counted. The block does not correct its counts after the fact.

Top module: `uas_monitor`

## Requirements
- R1: While available, `unavail` rises in the cycle after the clock edge that samples the `RUN_LEN`-th consecutive tick with `sec_sev`=1.
- R2: While `unavail` is 1 at a clock edge, that edge does not increment `ses_count`.
- R3: While `unavail` is 1 at a clock edge, that edge does not increment `es_count`.
- R4: While unavailable, `unavail` falls in the cycle after the clock edge that samples the `RUN_LEN`-th consecutive tick with `sec_err`=1 and `sec_sev`=0.
- R5: A tick that does not meet the condition being sought resets the run to zero. Clock cycles with `sec_tick`=0 neither advance nor break a run. A run also restarts from zero after every state change.
- R6: `state_chg` is 1 for exactly the first cycle of each new state, and is 0 at all other times.
- R7: `clr_cnt`=1 at a clock edge sets both counters to zero, even if the same edge would otherwise have incremented them.
- R8: Each counter stops at all-ones (2^`CNT_W`-1) and does not wrap.
- R9: While `rst_n`=0 at a clock edge, the block goes to the available state, clears both counters and the run, and drives `state_chg` to 0.
- R10: While available, a tick increments `es_count` when `sec_err` or `sec_sev` is 1 (when `SEV_IS_ERRORED`=1, the default). The same tick increments `ses_count` when `sec_sev` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe at the end of each second |
| sec_err | input | 1 | The second marked by this tick was errored |
| sec_sev | input | 1 | The second marked by this tick was severely errored |
| clr_cnt | input | 1 | Synchronous clear of both performance counters |
| unavail | output | 1 | 1 while the line is in the unavailable state |
| state_chg | output | 1 | One-cycle pulse on each state change |
| es_count | output | CNT_W | Saturating errored-second count |
| ses_count | output | CNT_W | Saturating severely-errored-second count |

## Verification
The bench targets the following corner cases:
- **Run broken one short.** A run of nine severely errored seconds is broken by a tenth that is not severe. A design that does not reset its run would then enter the unavailable state early.
- **Idle cycles inside a run.** Quiet cycles are placed between ticks. A design that counted clock cycles instead of ticks would flip the state at the wrong time.
- **Severe seconds while unavailable.** Severely errored seconds arrive while the line is unavailable. A design that let them advance the exit run, or that kept counting them, would leave the state too soon or have counters that drift.
- **Clear against increment, and saturation.** A clear coincides with an incrementing tick, and a narrow counter is driven past all-ones. These expose a wrong priority and wrap-around.

Long constrained-random phases that lean toward severe or mild seconds make the state flip many times. A free-running model in the bench checks every output on every cycle.

// File: rtl/uas_pkg.sv
package uas_pkg;

   typedef enum logic {
      LINE_AVAIL   = 1'b0,
      LINE_UNAVAIL = 1'b1
   } line_state_e;

   localparam int NUM_PERF = 2;
   localparam int IDX_ES   = 0;
   localparam int IDX_SES  = 1;

   function automatic line_state_e other_state(input line_state_e s);
      return (s == LINE_AVAIL) ? LINE_UNAVAIL : LINE_AVAIL;
   endfunction

endpackage

// File: rtl/uas_run_tracker.sv
module uas_run_tracker #(
   parameter int RUN_LEN = 10,
   localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             qualify,
   output logic [RUN_W-1:0] run_cnt,
   output logic             run_done
);
   localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_LEN - 1);

   logic [RUN_W-1:0] cnt_q;

   assign run_done = step && qualify && (cnt_q == LAST);
   assign run_cnt  = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         if (!qualify || run_done) cnt_q <= '0;
         else                      cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/uas_state_ctrl.sv
module uas_state_ctrl
   import uas_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flip,
   output line_state_e state,
   output logic        chg_pulse
);
   line_state_e state_q;
   logic        chg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LINE_AVAIL;
         chg_q   <= 1'b0;
      end else begin
         chg_q <= flip;
         if (flip) state_q <= other_state(state_q);
      end
   end

   assign state     = state_q;
   assign chg_pulse = chg_q;
endmodule

// File: rtl/uas_sat_counter.sv
module uas_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (inc && (cnt_q != TOP)) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;
endmodule

// File: rtl/uas_monitor.sv
module uas_monitor
   import uas_pkg::*;
#(
   parameter int RUN_LEN        = 10,
   parameter int CNT_W          = 16,
   parameter bit SEV_IS_ERRORED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sec_tick,
   input  logic             sec_err,
   input  logic             sec_sev,
   input  logic             clr_cnt,
   output logic             unavail,
   output logic             state_chg,
   output logic [CNT_W-1:0] es_count,
   output logic [CNT_W-1:0] ses_count
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("uas_monitor: RUN_LEN must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("uas_monitor: CNT_W must be in 2..32");
   end

   line_state_e      state;
   logic             qualify;
   logic             run_done;
   logic [RUN_W-1:0] run_cnt;
   logic             err_any;
   logic             avail;
   logic [NUM_PERF-1:0] inc_vec;
   logic [CNT_W-1:0]    cnt_arr [NUM_PERF];

   assign avail = (state == LINE_AVAIL);

   // entry wants severe seconds; exit wants errored-but-not-severe seconds
   always_comb begin
      if (avail) qualify = sec_sev;
      else       qualify = sec_err && !sec_sev;
   end

   if (SEV_IS_ERRORED) begin : g_sev_err
      assign err_any = sec_err || sec_sev;
   end else begin : g_err_only
      assign err_any = sec_err;
   end

   assign inc_vec[IDX_ES]  = sec_tick && avail && err_any;
   assign inc_vec[IDX_SES] = sec_tick && avail && sec_sev;

   uas_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (sec_tick),
      .qualify  (qualify),
      .run_cnt  (run_cnt),
      .run_done (run_done)
   );

   uas_state_ctrl u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .flip      (run_done),
      .state     (state),
      .chg_pulse (state_chg)
   );

   for (genvar g = 0; g < NUM_PERF; g++) begin : g_perf
      uas_sat_counter #(.W(CNT_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr_cnt),
         .inc   (inc_vec[g]),
         .count (cnt_arr[g])
      );
   end

   assign unavail   = !avail;
   assign es_count  = cnt_arr[IDX_ES];
   assign ses_count = cnt_arr[IDX_SES];
endmodule

// File: rtl/uas_monitor_checker.sv
module uas_monitor_checker #(
   parameter int RUN_LEN = 10,
   parameter int CNT_W   = 16,
   parameter int RUN_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sec_tick,
   input logic             sec_err,
   input logic             sec_sev,
   input logic             clr_cnt,
   input logic             unavail,
   input logic             state_chg,
   input logic [CNT_W-1:0] es_count,
   input logic [CNT_W-1:0] ses_count,
   input logic [RUN_W-1:0] run_cnt
);
   assert_run_below_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt < RUN_W'(RUN_LEN));

   assert_entry_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unavail) |-> $past(sec_tick && sec_sev));

   assert_exit_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unavail) |-> $past(sec_tick && sec_err && !sec_sev));

   assert_pulse_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      state_chg |-> (unavail != $past(unavail)));

   assert_change_has_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail != $past(unavail)) |-> state_chg);

   assert_ses_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail && !clr_cnt) |=> $stable(ses_count));

   assert_es_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (unavail && !clr_cnt) |=> $stable(es_count));

   assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt |=> (es_count == '0 && ses_count == '0));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((&ses_count) && !clr_cnt) |=> (&ses_count));

   assert_es_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((&es_count) && !clr_cnt) |=> (&es_count));
endmodule

bind uas_monitor uas_monitor_checker #(
   .RUN_LEN (RUN_LEN),
   .CNT_W   (CNT_W),
   .RUN_W   (RUN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .sec_err   (sec_err),
   .sec_sev   (sec_sev),
   .clr_cnt   (clr_cnt),
   .unavail   (unavail),
   .state_chg (state_chg),
   .es_count  (es_count),
   .ses_count (ses_count),
   .run_cnt   (run_cnt)
);

// File: tb/uas_monitor_tb.sv
`timescale 1ns/1ps
module uas_monitor_tb;
   localparam int RUN_LEN = 10;
   localparam int CNT_W   = 5;
   localparam int TOPV    = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0, sec_err = 1'b0, sec_sev = 1'b0, clr_cnt = 1'b0;
   logic unavail, state_chg;
   logic [CNT_W-1:0] es_count, ses_count;

   int checks = 0;
   int errors = 0;

   // bench model of the requirements
   int m_unavail = 0, m_chg = 0, m_run = 0, m_es = 0, m_ses = 0;

   always #2.5 clk = ~clk;

   uas_monitor #(.RUN_LEN(RUN_LEN), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .sec_err(sec_err),
      .sec_sev(sec_sev), .clr_cnt(clr_cnt), .unavail(unavail),
      .state_chg(state_chg), .es_count(es_count), .ses_count(ses_count)
   );

   function automatic int sat_inc(input int v);
      return (v >= TOPV) ? TOPV : v + 1;
   endfunction

   function automatic bit qualifies(input int st, input bit e, input bit s);
      return (st == 0) ? s : (e && !s);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1/R4 unavail", int'(unavail), m_unavail);
      chk("R6 state_chg", int'(state_chg), m_chg);
      chk("R2/R8/R10 ses_count", int'(ses_count), m_ses);
      chk("R3/R8/R10 es_count", int'(es_count), m_es);
   endtask

   // one clock: check at negedge, drive, then advance model at posedge
   task automatic cyc(input bit t, input bit e, input bit s, input bit c);
      @(negedge clk);
      compare_all();
      sec_tick = t; sec_err = e; sec_sev = s; clr_cnt = c;
      @(posedge clk);
      m_chg = 0;
      if (c) begin
         m_es = 0; m_ses = 0;
      end else if (t && m_unavail == 0) begin
         if (e || s) m_es = sat_inc(m_es);
         if (s)      m_ses = sat_inc(m_ses);
      end
      if (t) begin
         if (qualifies(m_unavail, e, s)) begin
            if (m_run == RUN_LEN - 1) begin
               m_run = 0; m_unavail = 1 - m_unavail; m_chg = 1;
            end else begin
               m_run++;
            end
         end else begin
            m_run = 0;
         end
      end
   endtask

   task automatic sec(input bit e, input bit s, input int gap);
      cyc(1'b1, e, s, 1'b0);
      for (int i = 0; i < gap; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int r;
      void'($urandom(32'd2024));
      // R9: outputs held at reset values during reset
      sec_tick = 1'b1; sec_sev = 1'b1; sec_err = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9 unavail in reset", int'(unavail), 0);
      chk("R9 state_chg in reset", int'(state_chg), 0);
      chk("R9 es in reset", int'(es_count), 0);
      chk("R9 ses in reset", int'(ses_count), 0);
      sec_tick = 1'b0; sec_sev = 1'b0; sec_err = 1'b0;
      rst_n = 1'b1;

      // R5: nine severe, then a break, then idle gaps inside a full run (R1)
      for (int i = 0; i < RUN_LEN - 1; i++) sec(1'b1, 1'b1, 0);
      sec(1'b1, 1'b0, 1);
      chk("R5 no entry after broken run", int'(unavail), 0);
      for (int i = 0; i < RUN_LEN; i++) sec(1'b0, 1'b1, 2);
      chk("R1 entered after full run", int'(unavail), 1);

      // R2/R3: severe and mild seconds while unavailable; clean second breaks exit run
      for (int i = 0; i < 5; i++) sec(1'b1, 1'b1, 0);
      for (int i = 0; i < RUN_LEN - 1; i++) sec(1'b1, 1'b0, 0);
      sec(1'b0, 1'b0, 0);
      chk("R5 no exit after broken run", int'(unavail), 1);
      for (int i = 0; i < RUN_LEN; i++) sec(1'b1, 1'b0, 1);
      chk("R4 left after full run", int'(unavail), 0);

      // R7: clear coincides with an incrementing tick
      cyc(1'b1, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk("R7 es after clear", int'(es_count), 0);
      chk("R7 ses after clear", int'(ses_count), 0);

      // R8: drive errored seconds past saturation
      for (int i = 0; i < TOPV + 8; i++) sec(1'b1, 1'b0, 0);
      chk("R8 es saturated", int'(es_count), TOPV);

      // random phases leaning severe or mild
      for (int p = 0; p < 60; p++) begin
         bit lean_sev = p[0];
         for (int i = 0; i < 60; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 30) cyc(1'b0, 1'b0, 1'b0, ($urandom_range(0, 49) == 0));
            else if (lean_sev) cyc(1'b1, 1'b1, (r < 95), 1'b0);
            else cyc(1'b1, (r < 96), (r > 98), 1'b0);
         end
      end

      @(negedge clk);
      compare_all();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule